// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits behind an HDLC deframer. Each received byte arrives with a valid strobe, a start marker on the first byte of a frame and an end marker on the last byte. The block reads the address field at the head of every frame and decides whether the frame is for this station. An accepted frame has its control field moved into a header register and the rest of its bytes passed on as a filtered stream towards the receive FIFO. A frame that fails the address test is dropped without trace: no stream bytes, no end-of-frame pulse, no header update. Flag detection, bit unstuffing and CRC checking happen upstream.

Five operating modes set how much of the header the block interprets. Two of them check the address and move the control field to the header register; they differ in how a two-byte (modulo-128) control field is handled. The other three are transparent variants: one checks only the station byte, one checks nothing, and one checks only the service byte. Configuration inputs are expected to hold still while a frame is in progress.

Top module: `hdlcaf_rx_filter`

## Requirements
- R1: While reset is held and on the first cycle after it, `fifo_vld`, `frm_end`, `hdr_ctrl` and `sap_cap` are all zero.
- R2: With `cfg_addr2`=1, in modes 0, 1 and 4, the first byte of a frame passes only if it equals `cfg_sap_a`, `cfg_sap_b`, 0xFE or 0xFC. In modes 0, 1, 2 and 4 and in the reserved codes 5 to 7, the first byte never reaches the stream.
- R3: With `cfg_addr2`=1, in modes 0, 1 and 2, the second byte passes only if it equals `cfg_tei_a`, `cfg_tei_b` or the group value 0xFF. A failure drops the frame.
- R4: With `cfg_addr2`=0, the address is the single first byte. In modes 0, 1 and 2 it passes only if it equals `cfg_tei_a` or `cfg_tei_b`. Here 0xFF is not a group match.
- R5: Mode 0 (`cfg_mode`=0) copies the control byte into `hdr_ctrl` and streams every later byte. With `cfg_ext`=1, a control byte whose bits [1:0] are not 2'b11 starts a two-byte control field. `hdr_ctrl` then becomes {second[3:0], first[3:0]}. When bits [1:0] are 2'b11, the control field is a single byte.
- R6: Mode 1 (`cfg_mode`=1) copies the first control byte into `hdr_ctrl`. With `cfg_ext`=1 and a two-byte control field, the second control byte goes to the stream.
- R7: Mode 2 (`cfg_mode`=2) compares only the station byte. With `cfg_addr2`=1 the first byte is not compared; it is loaded into `sap_cap` only once the frame is accepted. The control field is then handled as in mode 1. In no other mode does `sap_cap` change.
- R8: Mode 3 (`cfg_mode`=3) makes no comparison. Every byte of the frame, including the address bytes, goes to the stream, and `hdr_ctrl` is left unchanged.
- R9: Mode 4 (`cfg_mode`=4) compares only the first byte, against the set in R2. Every later byte goes to the stream, whatever `cfg_addr2` is, and `hdr_ctrl` is left unchanged.
- R10: A streamed byte appears on `fifo_data` with `fifo_vld` one cycle after it was presented. `fifo_last` is set on it exactly when it carried the end marker. `frm_end` pulses for one cycle, one cycle after the end marker of an accepted frame.
- R11: A frame that ends before its address field is complete is rejected: no `frm_end`, no stream bytes, no header change.
- R12: A start marker in the middle of a frame abandons that frame and starts parsing a new one from that byte. Bytes outside a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input byte valid |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| cfg_mode | input | 3 | Operating mode, codes 0 to 4 (5 to 7 act as 1) |
| cfg_addr2 | input | 1 | Two-byte address field |
| cfg_ext | input | 1 | Extended (modulo-128) control field |
| cfg_sap_a | input | 8 | First programmable service-byte target |
| cfg_sap_b | input | 8 | Second programmable service-byte target |
| cfg_tei_a | input | 8 | First programmable station-byte target |
| cfg_tei_b | input | 8 | Second programmable station-byte target |
| fifo_vld | output | 1 | Filtered stream byte valid |
| fifo_data | output | 8 | Filtered stream byte |
| fifo_last | output | 1 | Streamed byte is the frame's last |
| frm_end | output | 1 | Accepted frame has ended |
| hdr_ctrl | output | 8 | Header control register |
| sap_cap | output | 8 | Captured service byte (mode 2) |

## Verification
Every result of this block is one register stage deep. A streamed byte, its last flag and the end-of-frame pulse all show up in the cycle after the input byte. `hdr_ctrl` and `sap_cap` also take their new value one edge after the byte that writes them. The bench drives inputs just after the rising edge and samples on the falling edge. The directed latency test checks the falling edge of the same cycle (still empty) and of the next cycle (result present). The table-driven frames are judged only after three idle cycles, once every result is due. Stream contents are checked against the tail of the sent frame, since in every mode the forwarded bytes are a suffix of it.

// File: rtl/hdlcaf_pkg.sv
package hdlcaf_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t SAP_FIX_A = 8'hFE;
    localparam byte_t SAP_FIX_B = 8'hFC;
    localparam byte_t TEI_GROUP = 8'hFF;

    localparam int N_SAP_TGT = 4;
    localparam int N_TEI_TGT = 3;

    typedef enum logic [2:0] {
        MODE_AUTO     = 3'd0,
        MODE_NONAUTO  = 3'd1,
        MODE_TEI_ONLY = 3'd2,
        MODE_OPEN     = 3'd3,
        MODE_SAP_ONLY = 3'd4
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR2,
        ST_CTRL1,
        ST_CTRL2,
        ST_BODY,
        ST_SKIP
    } pstate_e;

    typedef enum logic [2:0] {
        RT_DROP,
        RT_FIFO,
        RT_HDR,
        RT_HDR_PACK,
        RT_SAP
    } route_e;

    typedef struct packed {
        logic  vld;
        byte_t data;
        logic  last;
    } fifo_beat_t;

    // A control byte opens a two-byte field unless it is an unnumbered one.
    function automatic logic ctrl_is_long(input logic [1:0] low_bits);
        return low_bits != 2'b11;
    endfunction

endpackage

// File: rtl/hdlcaf_match.sv
module hdlcaf_match
    import hdlcaf_pkg::*;
#(
    parameter int N_TGT = 4
) (
    input  byte_t                        val,
    input  logic [N_TGT-1:0][BYTE_W-1:0] tgt,
    input  logic [N_TGT-1:0]             en,
    output logic                         hit
);
    logic [N_TGT-1:0] eq;

    for (genvar g = 0; g < N_TGT; g++) begin : g_cmp
        assign eq[g] = en[g] && (val == tgt[g]);
    end

    assign hit = |eq;
endmodule

// File: rtl/hdlcaf_seq.sv
module hdlcaf_seq
    import hdlcaf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_vld,
    input  logic   in_sof,
    input  logic   in_eof,
    input  mode_e  mode,
    input  logic   addr2,
    input  logic   ext,
    input  logic   ctrl_long,
    input  logic   sap_hit,
    input  logic   tei_hit,
    output route_e route,
    output logic   acc_end,
    output logic   commit_sap,
    output logic   grp_en
);
    pstate_e state, nxt;

    // Group station value is honoured only on the second address byte (R3, R4)
    assign grp_en = !in_sof && (state == ST_ADDR2);

    always_comb begin
        nxt        = state;
        route      = RT_DROP;
        acc_end    = 1'b0;
        commit_sap = 1'b0;
        if (in_vld) begin
            if (in_sof) begin
                // R12: a start marker always restarts parsing
                case (mode)
                    MODE_OPEN: begin
                        route = RT_FIFO;
                        nxt   = ST_BODY;
                    end
                    MODE_SAP_ONLY: nxt = sap_hit ? ST_BODY : ST_SKIP;
                    MODE_TEI_ONLY: begin
                        if (addr2) begin
                            route = RT_SAP;
                            nxt   = ST_ADDR2;
                        end else begin
                            nxt = tei_hit ? ST_CTRL1 : ST_SKIP;
                        end
                    end
                    default: begin
                        if (addr2) nxt = sap_hit ? ST_ADDR2 : ST_SKIP;
                        else       nxt = tei_hit ? ST_CTRL1 : ST_SKIP;
                    end
                endcase
            end else begin
                case (state)
                    ST_ADDR2: begin
                        if (tei_hit) begin
                            nxt        = ST_CTRL1;
                            commit_sap = (mode == MODE_TEI_ONLY);
                        end else begin
                            nxt = ST_SKIP;
                        end
                    end
                    ST_CTRL1: begin
                        route = RT_HDR;
                        nxt   = (ext && ctrl_long) ? ST_CTRL2 : ST_BODY;
                    end
                    ST_CTRL2: begin
                        route = (mode == MODE_AUTO) ? RT_HDR_PACK : RT_FIFO;
                        nxt   = ST_BODY;
                    end
                    ST_BODY: route = RT_FIFO;
                    default: nxt = state;
                endcase
            end
            if (in_eof) begin
                // R11: only a frame past its address check reports an end
                acc_end = (nxt == ST_CTRL1) || (nxt == ST_CTRL2) || (nxt == ST_BODY);
                nxt     = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/hdlcaf_rx_filter.sv
module hdlcaf_rx_filter
    import hdlcaf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_vld,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic [2:0] cfg_mode,
    input  logic       cfg_addr2,
    input  logic       cfg_ext,
    input  logic [7:0] cfg_sap_a,
    input  logic [7:0] cfg_sap_b,
    input  logic [7:0] cfg_tei_a,
    input  logic [7:0] cfg_tei_b,
    output logic       fifo_vld,
    output logic [7:0] fifo_data,
    output logic       fifo_last,
    output logic       frm_end,
    output logic [7:0] hdr_ctrl,
    output logic [7:0] sap_cap
);
    logic       sap_hit, tei_hit, grp_en, acc_end, commit_sap;
    route_e     route;
    fifo_beat_t beat;
    byte_t      sap_pend;

    hdlcaf_match #(.N_TGT(N_SAP_TGT)) u_sap_match (
        .val (in_data),
        .tgt ({SAP_FIX_B, SAP_FIX_A, cfg_sap_b, cfg_sap_a}),
        .en  ({N_SAP_TGT{1'b1}}),
        .hit (sap_hit)
    );

    hdlcaf_match #(.N_TGT(N_TEI_TGT)) u_tei_match (
        .val (in_data),
        .tgt ({TEI_GROUP, cfg_tei_b, cfg_tei_a}),
        .en  ({grp_en, 2'b11}),
        .hit (tei_hit)
    );

    hdlcaf_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .in_vld     (in_vld),
        .in_sof     (in_sof),
        .in_eof     (in_eof),
        .mode       (mode_e'(cfg_mode)),
        .addr2      (cfg_addr2),
        .ext        (cfg_ext),
        .ctrl_long  (ctrl_is_long(in_data[1:0])),
        .sap_hit    (sap_hit),
        .tei_hit    (tei_hit),
        .route      (route),
        .acc_end    (acc_end),
        .commit_sap (commit_sap),
        .grp_en     (grp_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            beat     <= '0;
            frm_end  <= 1'b0;
            hdr_ctrl <= '0;
            sap_pend <= '0;
            sap_cap  <= '0;
        end else begin
            beat.vld  <= (route == RT_FIFO);
            beat.data <= in_data;
            beat.last <= in_eof;
            frm_end   <= acc_end;
            case (route)
                RT_HDR:      hdr_ctrl <= in_data;
                RT_HDR_PACK: hdr_ctrl <= {in_data[3:0], hdr_ctrl[3:0]}; // R5
                RT_SAP:      sap_pend <= in_data;
                default:     ;
            endcase
            if (commit_sap) sap_cap <= sap_pend; // R7
        end
    end

    assign fifo_vld  = beat.vld;
    assign fifo_data = beat.data;
    assign fifo_last = beat.last;
endmodule

// File: rtl/hdlcaf_rx_filter_chk.sv
module hdlcaf_rx_filter_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_vld,
    input logic [7:0] in_data,
    input logic       in_sof,
    input logic       in_eof,
    input logic [2:0] cfg_mode,
    input logic       fifo_vld,
    input logic [7:0] fifo_data,
    input logic       fifo_last,
    input logic       frm_end,
    input logic [7:0] hdr_ctrl,
    input logic [7:0] sap_cap
);
    AST_FIFO_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
        fifo_vld |-> $past(in_vld)); // R10
    AST_LAST_FOLLOWS_EOF: assert property (@(posedge clk) disable iff (rst)
        (fifo_vld && fifo_last) |-> $past(in_eof)); // R10
    AST_END_FOLLOWS_EOF: assert property (@(posedge clk) disable iff (rst)
        frm_end |-> $past(in_vld && in_eof)); // R10
    AST_ADDR_NOT_STREAMED: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_sof && cfg_mode != 3'd3) |=> !fifo_vld); // R2
    AST_OPEN_FORWARDS: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_sof && cfg_mode == 3'd3) |=> (fifo_vld && fifo_data == $past(in_data))); // R8
    AST_SAP_CAP_HELD: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode != 3'd2) |=> $stable(sap_cap)); // R7
    AST_HDR_HELD_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 3'd3 || cfg_mode == 3'd4) |=> $stable(hdr_ctrl)); // R9
endmodule

bind hdlcaf_rx_filter hdlcaf_rx_filter_chk u_chk (.*);

// File: tb/hdlcaf_rx_filter_tb.sv
module hdlcaf_rx_filter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int N_VEC      = 16;

    // {mode, addr2, ext, len, bytes b0..b5, exp_end, exp_nfifo, exp_hdr, exp_sap}
    localparam logic [75:0] VEC [N_VEC] = '{
        {3'd0, 1'b1, 1'b0, 3'd5, 48'h1041_03A1_A200, 1'b1, 3'd2, 8'h03, 8'h00}, // R2 R3 R5 sap_a/tei_a
        {3'd0, 1'b1, 1'b0, 3'd4, 48'hFEFF_13B1_0000, 1'b1, 3'd1, 8'h13, 8'h00}, // R2 R3 fixed FE, group FF
        {3'd0, 1'b1, 1'b0, 3'd4, 48'h3341_03A1_0000, 1'b0, 3'd0, 8'h13, 8'h00}, // R2 service miss
        {3'd0, 1'b1, 1'b0, 3'd3, 48'hFC55_0700_0000, 1'b0, 3'd0, 8'h13, 8'h00}, // R3 station miss
        {3'd0, 1'b0, 1'b0, 3'd4, 48'h7E05_C1C2_0000, 1'b1, 3'd2, 8'h05, 8'h00}, // R4 tei_b single byte
        {3'd0, 1'b0, 1'b0, 3'd3, 48'hFF05_C100_0000, 1'b0, 3'd0, 8'h05, 8'h00}, // R4 no group in 1-byte
        {3'd0, 1'b1, 1'b1, 3'd5, 48'h227E_0A36_D100, 1'b1, 3'd1, 8'h6A, 8'h00}, // R5 packed control
        {3'd0, 1'b1, 1'b1, 3'd5, 48'h227E_13D1_D200, 1'b1, 3'd2, 8'h13, 8'h00}, // R5 unnumbered one byte
        {3'd1, 1'b1, 1'b1, 3'd5, 48'h1041_0A36_E100, 1'b1, 3'd2, 8'h0A, 8'h00}, // R6
        {3'd3, 1'b1, 1'b0, 3'd3, 48'h9988_7700_0000, 1'b1, 3'd3, 8'h0A, 8'h00}, // R8
        {3'd4, 1'b1, 1'b0, 3'd3, 48'hFE12_3400_0000, 1'b1, 3'd2, 8'h0A, 8'h00}, // R9 hit
        {3'd4, 1'b1, 1'b0, 3'd3, 48'h1112_3400_0000, 1'b0, 3'd0, 8'h0A, 8'h00}, // R9 miss
        {3'd2, 1'b1, 1'b0, 3'd4, 48'h5A41_21F1_0000, 1'b1, 3'd1, 8'h21, 8'h5A}, // R7 accept, capture
        {3'd2, 1'b1, 1'b0, 3'd3, 48'h6B42_2200_0000, 1'b0, 3'd0, 8'h21, 8'h5A}, // R7 reject, no capture
        {3'd0, 1'b1, 1'b0, 3'd1, 48'h1000_0000_0000, 1'b0, 3'd0, 8'h21, 8'h5A}, // R11 cut short
        {3'd0, 1'b0, 1'b0, 3'd1, 48'h4100_0000_0000, 1'b1, 3'd0, 8'h21, 8'h5A}  // R4 R10 address-only frame
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_vld = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_data = '0;
    logic [2:0] cfg_mode = '0;
    logic       cfg_addr2 = 1'b1, cfg_ext = 1'b0;
    logic [7:0] cfg_sap_a = 8'h10, cfg_sap_b = 8'h22, cfg_tei_a = 8'h41, cfg_tei_b = 8'h7E;
    logic       fifo_vld, fifo_last, frm_end;
    logic [7:0] fifo_data, hdr_ctrl, sap_cap;

    int n_chk = 0, n_bad = 0;
    int mon_n = 0, mon_last = 0, mon_end = 0;
    logic [7:0] cap [8];

    hdlcaf_rx_filter u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (!rst) begin
            if (fifo_vld) begin
                if (mon_n < 8) cap[mon_n] = fifo_data;
                mon_n = mon_n + 1;
                if (fifo_last) mon_last = mon_last + 1;
            end
            if (frm_end) mon_end = mon_end + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] d, input logic sof, input logic eof);
        @(posedge clk); #1;
        in_vld = 1'b1; in_data = d; in_sof = sof; in_eof = eof;
    endtask

    task automatic go_idle();
        @(posedge clk); #1;
        in_vld = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic clear_mon();
        mon_n = 0; mon_last = 0; mon_end = 0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 fifo_vld after reset", 32'(fifo_vld), 0);
        chk("R1 frm_end after reset", 32'(frm_end), 0);
        chk("R1 hdr_ctrl after reset", 32'(hdr_ctrl), 0);
        chk("R1 sap_cap after reset", 32'(sap_cap), 0);

        for (int v = 0; v < N_VEC; v++) begin
            logic [75:0] e;
            int len, nf;
            e = VEC[v];
            len = int'(e[70:68]);
            nf  = int'(e[18:16]);
            cfg_mode = e[75:73]; cfg_addr2 = e[72]; cfg_ext = e[71];
            @(posedge clk); #1;
            clear_mon();
            for (int i = 0; i < len; i++)
                put_byte(e[67-8*i -: 8], i == 0, i == len - 1);
            go_idle();
            $display("entry %0d", v);
            chk("R10 R11 frame end pulses", 32'(mon_end), 32'(e[19]));
            chk("R2-stream byte count", 32'(mon_n), 32'(nf));
            for (int k = 0; k < nf && k < 8; k++)
                chk("R10 streamed byte", 32'(cap[k]), 32'(e[67-8*(len-nf+k) -: 8]));
            chk("R10 last flag count", 32'(mon_last), (nf > 0) ? 1 : 0);
            chk("R5 R6 header register", 32'(hdr_ctrl), 32'(e[15:8]));
            chk("R7 captured service byte", 32'(sap_cap), 32'(e[7:0]));
        end

        // R12: restart on a new start marker inside a rejected frame
        cfg_mode = 3'd0; cfg_addr2 = 1'b1; cfg_ext = 1'b0;
        @(posedge clk); #1;
        clear_mon();
        put_byte(8'h55, 1'b1, 1'b0);
        put_byte(8'h66, 1'b0, 1'b0);
        put_byte(8'h10, 1'b1, 1'b0);
        put_byte(8'h41, 1'b0, 1'b0);
        put_byte(8'h03, 1'b0, 1'b0);
        put_byte(8'hA7, 1'b0, 1'b1);
        go_idle();
        chk("R12 restarted frame end", 32'(mon_end), 1);
        chk("R12 restarted stream count", 32'(mon_n), 1);
        chk("R12 restarted stream byte", 32'(cap[0]), 32'h A7);
        chk("R12 restarted header", 32'(hdr_ctrl), 32'h03);

        // R12: bytes without an open frame are ignored
        clear_mon();
        put_byte(8'h10, 1'b0, 1'b0);
        put_byte(8'h41, 1'b0, 1'b0);
        put_byte(8'h0F, 1'b0, 1'b1);
        go_idle();
        chk("R12 stray bytes stream", 32'(mon_n), 0);
        chk("R12 stray bytes end", 32'(mon_end), 0);
        chk("R12 stray bytes header", 32'(hdr_ctrl), 32'h03);

        // R10: exact one-cycle latency in the open mode
        cfg_mode = 3'd3;
        @(posedge clk); #1;
        in_vld = 1'b1; in_data = 8'hAB; in_sof = 1'b1; in_eof = 1'b1;
        @(negedge clk);
        chk("R10 no output in input cycle", 32'(fifo_vld), 0);
        @(posedge clk); #1;
        in_vld = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        @(negedge clk);
        chk("R10 valid one cycle later", 32'(fifo_vld), 1);
        chk("R10 data one cycle later", 32'(fifo_data), 32'h AB);
        chk("R10 last one cycle later", 32'(fifo_last), 1);
        chk("R10 end pulse one cycle later", 32'(frm_end), 1);
        @(negedge clk);
        chk("R10 end pulse lasts one cycle", 32'(frm_end), 0);
        chk("R10 valid drops", 32'(fifo_vld), 0);

        summary();
        $finish;
    end
endmodule